// File: doc/BRIEF.md
# Triggered Capture Controller for an Eight-Channel Logic Analyzer

This block sequences the capture side of an eight-channel logic analyzer. A record command arms it, after which every sample strobe offers the eight input bits for storage in an external circular buffer. A write is issued only when the sample differs from the one before it, so runs of identical data take up a single entry. While armed, the controller compares each sample against a programmable trigger word. After a match, it counts the post-trigger writes up to a quota chosen by a two-bit frame select. The quota leaves one eighth, one half or seven eighths of the buffer holding history from before the trigger.

When the quota is reached, the write pointer freezes and the controller switches to playback. A slower playback strobe then walks the buffer once, starting from the oldest entry. The read address also serves as the horizontal display position. After one full pass the controller re-arms by itself and capture resumes where the write pointer stopped. A separate real-time mode bypasses recording and passes each sampled input straight to a live output.

Top module: `la_capture_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the mode output is 0 (idle), and mem_we and rd_en are low.
- R2: In idle with rt_mode low, a rec_cmd pulse makes mode 1 (armed) in the next cycle. rec_cmd has no effect in any other mode.
- R3: In modes 1 and 2, a cycle with smp_en high produces mem_we high in the next cycle only if this is the first sample since capture began or din differs from the previous captured sample. Each write carries mem_wdata equal to that din and mem_waddr equal to the write pointer. The write pointer advances by one modulo DEPTH per write.
- R4: In armed mode, a sampled din equal to trig_word moves the mode to 2 (post-trigger) in the next cycle, whether or not that sample is written.
- R5: The post-trigger write quota is 7*DEPTH/8 for frame_sel 0, DEPTH/2 for frame_sel 1, and DEPTH/8 for frame_sel 2 or 3. Only writes made in mode 2 count toward it. The write that brings the count to the quota moves the mode to 3 (playback), and no further writes are issued.
- R6: In playback, each play_en cycle gives rd_en high in the next cycle. The first rd_addr is the oldest entry (the frozen write pointer), and each later read advances by one modulo DEPTH. play_en has no effect outside playback.
- R7: After DEPTH reads, the mode returns to 1 (armed) by itself, without a rec_cmd.
- R8: rt_mode high forces mode 0 in the next cycle and suppresses writes and reads. A cycle with both rt_mode and smp_en high loads din into live_data one cycle later.
- R9: The write pointer does not move during playback, so the first write after re-arming uses the address where the previous capture stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe for capture |
| play_en | input | 1 | Playback read strobe |
| rec_cmd | input | 1 | Arm request |
| rt_mode | input | 1 | Real-time pass-through select |
| frame_sel | input | 2 | Pre-trigger fraction select |
| trig_word | input | 8 | Trigger comparison value |
| din | input | 8 | Sampled channel data |
| mem_we | output | 1 | Buffer write strobe |
| mem_waddr | output | AW | Buffer write address |
| mem_wdata | output | 8 | Buffer write data |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | AW | Buffer read address and horizontal position |
| live_data | output | 8 | Real-time sample output |
| mode | output | 2 | 0 idle, 1 armed, 2 post-trigger, 3 playback |

## Verification
Two functions can fall in the same sample: a trigger match and change suppression. A trigger word repeated on consecutive samples must move the controller to post-trigger with no write in that cycle. The bench provokes this by drawing din from a four-value alphabet that contains the trigger word, so repeats are frequent. It judges each case against a bench model that advances the mode independently of the write decision. Quota completion is a second coincidence: the stop write and the switch to playback share one cycle. Any sample strobe after that cycle must be ignored.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_PLAY  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/la_change_det.sv
module la_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_on,
    input  logic         stb,
    input  logic [W-1:0] din,
    output logic         changed
);
    logic [W-1:0] prev_d, prev_q;
    logic         have_d, have_q;

    always_comb begin
        prev_d = prev_q;
        have_d = have_q;
        if (!cap_on) begin
            have_d = 1'b0;
        end else if (stb) begin
            prev_d = din;
            have_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            have_q <= have_d;
        end
    end

    assign changed = !have_q || (din != prev_q);
endmodule

// File: rtl/la_frame_quota.sv
module la_frame_quota #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [1:0]    sel,
    output logic [AW-1:0] quota
);
    localparam int EIGHTH = DEPTH / 8;
    localparam logic [AW-1:0] Q_SEVEN = AW'(DEPTH - EIGHTH);
    localparam logic [AW-1:0] Q_HALF  = AW'(DEPTH / 2);
    localparam logic [AW-1:0] Q_ONE   = AW'(EIGHTH);

    always_comb begin
        case (sel)
            2'd0:    quota = Q_SEVEN;
            2'd1:    quota = Q_HALF;
            default: quota = Q_ONE;
        endcase
    end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
    import la_cap_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic          play_en,
    input  logic          rec_cmd,
    input  logic          rt_mode,
    input  logic [1:0]    frame_sel,
    input  logic [DW-1:0] trig_word,
    input  logic [DW-1:0] din,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] live_data,
    output logic [1:0]    mode
);
    localparam logic [AW-1:0] LAST_RD = AW'(DEPTH - 1);

    typedef struct packed {
        cap_state_e    st;
        logic [AW-1:0] wptr;
        logic [AW-1:0] post;
        logic [AW-1:0] rptr;
        logic [AW-1:0] pcnt;
        logic          we;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic          rd;
        logic [AW-1:0] raddr;
        logic [DW-1:0] live;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic          cap_on;
    logic          changed;
    logic [AW-1:0] quota;
    logic [AW:0]   post_inc;

    assign cap_on   = (r_q.st == ST_ARMED) || (r_q.st == ST_POST);
    assign post_inc = {1'b0, r_q.post} + 1'b1;

    la_change_det #(.W(DW)) i_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_on  (cap_on),
        .stb     (smp_en),
        .din     (din),
        .changed (changed)
    );

    la_frame_quota #(.DEPTH(DEPTH), .AW(AW)) i_quota (
        .sel   (frame_sel),
        .quota (quota)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        r_d.rd = 1'b0;
        if (smp_en && rt_mode) begin
            r_d.live = din;
        end
        if (rt_mode) begin
            r_d.st = ST_IDLE;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (rec_cmd) r_d.st = ST_ARMED;
                end
                ST_ARMED, ST_POST: begin
                    if (smp_en) begin
                        if (changed) begin
                            r_d.we    = 1'b1;
                            r_d.waddr = r_q.wptr;
                            r_d.wdata = din;
                            r_d.wptr  = r_q.wptr + 1'b1;
                        end
                        if (r_q.st == ST_ARMED) begin
                            if (din == trig_word) begin
                                r_d.st   = ST_POST;
                                r_d.post = '0;
                            end
                        end else if (changed) begin
                            if (post_inc >= {1'b0, quota}) begin
                                r_d.st   = ST_PLAY;
                                r_d.rptr = r_q.wptr + 1'b1;
                                r_d.pcnt = '0;
                            end else begin
                                r_d.post = post_inc[AW-1:0];
                            end
                        end
                    end
                end
                default: begin
                    if (play_en) begin
                        r_d.rd    = 1'b1;
                        r_d.raddr = r_q.rptr;
                        r_d.rptr  = r_q.rptr + 1'b1;
                        r_d.pcnt  = r_q.pcnt + 1'b1;
                        if (r_q.pcnt == LAST_RD) r_d.st = ST_ARMED;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_waddr = r_q.waddr;
    assign mem_wdata = r_q.wdata;
    assign rd_en     = r_q.rd;
    assign rd_addr   = r_q.raddr;
    assign live_data = r_q.live;
    assign mode      = r_q.st;

    AST_WRITE_WHEN_CAPTURING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(r_q.st) == ST_ARMED || $past(r_q.st) == ST_POST)); // R3
    AST_READ_ONLY_IN_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ($past(r_q.st) == ST_PLAY)); // R6
    AST_WPTR_HELD_IN_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_PLAY) |-> $stable(r_q.wptr)); // R9
    AST_REALTIME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rt_mode |=> (mode == 2'd0 && !mem_we && !rd_en)); // R8
    AST_PLAY_ENTRY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) == 2'd2) |-> mem_we); // R5
endmodule

// File: tb/test_la_capture_ctrl.sv
module test_la_capture_ctrl;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_en = 1'b0, play_en = 1'b0, rec_cmd = 1'b0, rt_mode = 1'b0;
    logic [1:0]    frame_sel = 2'd0;
    logic [7:0]    trig_word = 8'h5A, din = 8'h00;
    logic          mem_we, rd_en;
    logic [AW-1:0] mem_waddr, rd_addr;
    logic [7:0]    mem_wdata, live_data;
    logic [1:0]    mode;

    always #2.5 clk = ~clk;

    la_capture_ctrl #(.DEPTH(DEPTH)) i_la_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .play_en(play_en),
        .rec_cmd(rec_cmd), .rt_mode(rt_mode), .frame_sel(frame_sel),
        .trig_word(trig_word), .din(din), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .rd_en(rd_en),
        .rd_addr(rd_addr), .live_data(live_data), .mode(mode)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    int m_st = 0, m_wptr = 0, m_post = 0, m_rptr = 0, m_pcnt = 0;
    bit m_have = 0;
    logic [7:0] m_prev = 0;
    bit e_we = 0, e_rd = 0;
    int e_waddr = 0, e_raddr = 0;
    logic [7:0] e_wdata = 0, e_live = 0;
    string e_mtag = "R1";
    string e_wtag = "R3";
    bit after_play = 0;

    function automatic int quota_of(input logic [1:0] s);
        if (s == 2'd0) return DEPTH - DEPTH / 8;
        if (s == 2'd1) return DEPTH / 2;
        return DEPTH / 8;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit cap, chg;
        int nst;
        cap = (m_st == 1 || m_st == 2);
        chg = !m_have || (din != m_prev);
        nst = m_st;
        e_we = 0; e_rd = 0;
        e_mtag = "R2";
        e_wtag = after_play ? "R9" : "R3";
        if (smp_en && rt_mode) e_live = din;
        if (rt_mode) begin
            nst = 0; e_mtag = "R8";
        end else if (m_st == 0) begin
            if (rec_cmd) nst = 1;
        end else if (cap) begin
            if (m_st == 2) e_mtag = "R5";
            if (smp_en) begin
                if (chg) begin
                    e_we = 1; e_waddr = m_wptr; e_wdata = din;
                    m_wptr = (m_wptr + 1) % DEPTH;
                    after_play = 0;
                end
                if (m_st == 1) begin
                    if (din == trig_word) begin nst = 2; m_post = 0; e_mtag = "R4"; end
                end else if (chg) begin
                    if (m_post + 1 >= quota_of(frame_sel)) begin
                        nst = 3; m_rptr = m_wptr; m_pcnt = 0;
                    end else m_post++;
                end
            end
        end else begin
            e_mtag = "R7";
            if (play_en) begin
                e_rd = 1; e_raddr = m_rptr;
                m_rptr = (m_rptr + 1) % DEPTH;
                if (m_pcnt == DEPTH - 1) begin nst = 1; after_play = 1; end
                m_pcnt++;
            end
        end
        if (!cap) m_have = 0;
        else if (smp_en) begin m_have = 1; m_prev = din; end
        m_st = nst;
    endtask

    task automatic compare();
        check({e_mtag, " mode"}, mode, m_st);
        check(e_wtag, mem_we, e_we);
        if (e_we) begin
            check({e_wtag, " waddr"}, mem_waddr, e_waddr);
            check("R3 wdata", mem_wdata, e_wdata);
        end
        check("R6 rd_en", rd_en, e_rd);
        if (e_rd) check("R6 rd_addr", rd_addr, e_raddr);
        check("R8 live", live_data, e_live);
    endtask

    function automatic logic [7:0] pick_din();
        case ($urandom_range(0, 3))
            0: return trig_word;
            1: return 8'h11;
            2: return 8'hC3;
            default: return 8'h00;
        endcase
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mode in reset", mode, 0);
        check("R1 we in reset", mem_we, 0);
        check("R1 rd in reset", rd_en, 0);
        rst_n = 1'b1;
        model_step();
        @(negedge clk);
        compare();
        // directed: real-time pass-through
        rt_mode = 1; smp_en = 1; din = 8'hA7; rec_cmd = 1;
        model_step();
        @(negedge clk); compare();
        check("R8 live follows din", live_data, 8'hA7);
        check("R8 rec_cmd ignored in rt", mode, 0);
        rt_mode = 0; smp_en = 0; rec_cmd = 0;
        // directed: play_en in idle is ignored
        play_en = 1;
        model_step();
        @(negedge clk); compare();
        check("R6 play_en ignored in idle", rd_en, 0);
        play_en = 0;
        // directed: arm, then trigger on a repeated (unwritten) sample
        rec_cmd = 1; frame_sel = 2'd2;
        model_step();
        @(negedge clk); compare();
        check("R2 armed", mode, 1);
        rec_cmd = 0; smp_en = 1; din = trig_word;
        model_step();
        @(negedge clk); compare();
        check("R4 trigger on first sample", mode, 2);
        din = trig_word;
        model_step();
        @(negedge clk); compare();
        check("R3 repeat not written", mem_we, 0);
        // random run
        for (int cyc = 0; cyc < 60000; cyc++) begin
            smp_en   = ($urandom_range(0, 9) < 7);
            play_en  = ($urandom_range(0, 1) == 1);
            rec_cmd  = ($urandom_range(0, 19) == 0);
            rt_mode  = ($urandom_range(0, 499) == 0);
            if ($urandom_range(0, 299) == 0) frame_sel = 2'($urandom_range(0, 3));
            din = pick_din();
            model_step();
            @(negedge clk);
            compare();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule